// File: doc/BRIEF.md
# Sixteen-Pin Register-Mapped I/O Port

This block is a 16-pin general-purpose I/O port. It is controlled through a simple single-cycle register bus. The bus carries read and write strobes, a transfer-size code, a byte offset and write data. It returns registered read data and a two-bit error code.

Software reaches five pieces of state:
- a peripheral-function mask
- a pin data register, which has a write-one-to-set alias and a write-one-to-clear alias
- a direction register, which can only be changed through its own set and clear aliases
- an input-listen mask
- a 32-bit pin-routing word

The output side works as follows. Some data-changing writes cause a refresh. On a refresh, every pin that is not listening as an input presents its data bit on `pin_out` and pulses `pin_upd` for one cycle.

The input side works as follows. A pin event carries a multi-bit level, which is reduced to 0 or 1. The event is passed to the sample outputs only when three conditions hold together: the pin is not driven as an output, it is listening, and its peripheral-function bit is set.

No path in this block carries streamed data. The bus has no wait states and no back-pressure, and sample and update strobes are single-cycle pulses with no ready. The consumer must take them in the cycle they appear.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset, every register reads as zero. After reset, `bus_rdata`, `bus_err`, `pin_out`, `pin_upd`, `smp_stb` and `smp_lvl` are all zero.
- R2: The size code `bus_size` is encoded as follows: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. The routing word at offset 0x1C must be accessed with size 2. Every other offset must be accessed with size 1. A wrong size gives `bus_err` = 1 and read data zero, and it changes no register.
- R3: The mapped offsets are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C. Any other offset is unmapped. This includes offsets of 0x20 or more and offsets that are not a multiple of 4. An unmapped offset accessed with size 1 gives `bus_err` = 2 and read data zero. An unmapped offset accessed with any other size gives `bus_err` = 1, because a size error takes priority.
- R4: A write to 0x04 replaces the data register. A write to 0x08 ORs the written bits into it. A write to 0x0C clears the data bits written as 1.
- R5: The direction register has no plain-write offset. A write to 0x10 ORs bits into it, and a write to 0x14 clears the bits written as 1.
- R6: The peripheral-function mask is at 0x00 and the listen mask is at 0x18. Reads at 0x00 and 0x18 return those masks. Reads at 0x04, 0x08 and 0x0C all return the data register. Reads at 0x10 and 0x14 both return the direction register. Each 16-bit value is zero-extended to 32 bits.
- R7: After a legal write to 0x04, 0x08, 0x0C or 0x10, the next cycle shows the updated outputs. In that cycle, each pin i whose listen bit is 0 has `pin_out[i]` equal to data bit i and `pin_upd[i]` = 1, for that single cycle only. A listening pin keeps its `pin_out` and raises no strobe.
- R8: A write to 0x14, 0x00, 0x18 or 0x1C raises no `pin_upd` and leaves `pin_out` unchanged. An erroring access does the same.
- R9: A `pin_evt[i]` pulse carries the level `pin_lvl[2i+1:2i]`. That level counts as 1 when it is nonzero. The next cycle gives `smp_stb[i]` = 1 and `smp_lvl[i]` equal to that level, but only if direction bit i is 0, listen bit i is 1 and function bit i is 1. Otherwise there is no strobe and `smp_lvl[i]` is held.
- R10: Read data and the error code are registered. They are valid in the cycle after the strobe and are zero in any cycle that follows no access.
- R11: The routing word at 0x1C stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (wins if both strobes are high) |
| bus_size | input | 2 | Transfer size code |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 2 | Registered error code: 0 none, 1 size, 2 unmapped |
| pin_out | output | 16 | Pin output values |
| pin_upd | output | 16 | Per-pin refresh pulse |
| pin_evt | input | 16 | Per-pin input event strobe |
| pin_lvl | input | 32 | Two-bit level per pin |
| smp_stb | output | 16 | Per-pin forwarded sample strobe |
| smp_lvl | output | 16 | Last forwarded level per pin |

## Verification
The assertions assume that at most one bus access happens per cycle. They also assume that `bus_rd` and `bus_wr` are never both high with the intent of a read, and that input events arrive on cycles without a conflicting register write to the same gating masks.

The stimulus keeps within these limits. Every access is driven as a one-cycle strobe followed by an idle cycle, and pin events are issued only between bus accesses. Under these limits, a register value seen one cycle after an edge is the value that decided that edge's refresh or forwarding.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_SIZE     = 2'd1;
  localparam logic [1:0] ERR_UNMAPPED = 2'd2;

  // Register slot, taken from offset bits [4:2]; the order is the address map.
  typedef enum logic [2:0] {
    RS_FUNC   = 3'd0,
    RS_DATA   = 3'd1,
    RS_DSET   = 3'd2,
    RS_DCLR   = 3'd3,
    RS_DIRSET = 3'd4,
    RS_DIRCLR = 3'd5,
    RS_LISTEN = 3'd6,
    RS_ROUTE  = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_alias_pkg::*;
#(
  parameter int unsigned OFF_W = 6
) (
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] addr,
  output reg_sel_e         sel,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [1:0]       err
);

  // Offset bits that may be nonzero in a mapped offset.
  localparam logic [OFF_W-1:0] SLOT_BITS = OFF_W'(5'h1C);
  localparam logic [OFF_W-1:0] ROUTE_OFF = OFF_W'(5'h1C);

  logic access;
  logic mapped;
  logic route_off;
  logic size_ok;

  always_comb begin
    access    = rd | wr;
    mapped    = (addr & ~SLOT_BITS) == '0;
    route_off = addr == ROUTE_OFF;
    size_ok   = route_off ? (size == SZ_WORD) : (size == SZ_HALF);
    sel       = reg_sel_e'(addr[4:2]);
    if (!access)       err = ERR_NONE;
    else if (!size_ok) err = ERR_SIZE;
    else if (!mapped)  err = ERR_UNMAPPED;
    else               err = ERR_NONE;
    wr_ok = wr & size_ok & mapped;
    rd_ok = rd & ~wr & size_ok & mapped;
  end

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_alias_pkg::*;
#(
  parameter int unsigned NPIN  = 16,
  parameter int unsigned MUX_W = 32,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic             rd_ok,
  input  reg_sel_e         sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [NPIN-1:0]  fer_q,
  output logic [NPIN-1:0]  data_q,
  output logic [NPIN-1:0]  dir_q,
  output logic [NPIN-1:0]  inen_q,
  output logic [MUX_W-1:0] mux_q,
  output logic [NPIN-1:0]  data_nxt,
  output logic             refresh
);

  logic [NPIN-1:0] wbits;
  logic [NPIN-1:0] dir_nxt;
  logic [DW-1:0]   rd_val;

  always_comb begin
    wbits    = wdata[NPIN-1:0];
    data_nxt = data_q;
    dir_nxt  = dir_q;
    refresh  = 1'b0;
    if (wr_ok) begin
      unique case (sel)
        RS_DATA:   begin data_nxt = wbits;           refresh = 1'b1; end
        RS_DSET:   begin data_nxt = data_q | wbits;  refresh = 1'b1; end
        RS_DCLR:   begin data_nxt = data_q & ~wbits; refresh = 1'b1; end
        RS_DIRSET: begin dir_nxt  = dir_q | wbits;   refresh = 1'b1; end
        RS_DIRCLR: dir_nxt = dir_q & ~wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      RS_FUNC:                    rd_val = DW'(fer_q);
      RS_DATA, RS_DSET, RS_DCLR:  rd_val = DW'(data_q);
      RS_DIRSET, RS_DIRCLR:       rd_val = DW'(dir_q);
      RS_LISTEN:                  rd_val = DW'(inen_q);
      default:                    rd_val = DW'(mux_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fer_q  <= '0;
      data_q <= '0;
      dir_q  <= '0;
      inen_q <= '0;
      mux_q  <= '0;
      rdata  <= '0;
    end else begin
      data_q <= data_nxt;
      dir_q  <= dir_nxt;
      if (wr_ok && sel == RS_FUNC)   fer_q  <= wbits;
      if (wr_ok && sel == RS_LISTEN) inen_q <= wbits;
      if (wr_ok && sel == RS_ROUTE)  mux_q  <= wdata[MUX_W-1:0];
      rdata <= rd_ok ? rd_val : '0;
    end
  end

endmodule

// File: rtl/gpio_pin_io.sv
module gpio_pin_io #(
  parameter int unsigned NPIN  = 16,
  parameter int unsigned LVL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  refresh,
  input  logic [NPIN-1:0]       data_nxt,
  input  logic [NPIN-1:0]       inen,
  input  logic [NPIN-1:0]       dir,
  input  logic [NPIN-1:0]       fer,
  input  logic [NPIN-1:0]       pin_evt,
  input  logic [NPIN*LVL_W-1:0] pin_lvl,
  output logic [NPIN-1:0]       pin_out,
  output logic [NPIN-1:0]       pin_upd,
  output logic [NPIN-1:0]       smp_stb,
  output logic [NPIN-1:0]       smp_lvl
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic lvl_bit;
    logic listen;
    logic drive;
    logic out_r;
    logic upd_r;
    logic stb_r;
    logic lvl_r;

    assign lvl_bit = |pin_lvl[i*LVL_W +: LVL_W];
    assign listen  = fer[i] & inen[i] & ~dir[i];
    assign drive   = refresh & ~inen[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_r <= 1'b0;
        upd_r <= 1'b0;
        stb_r <= 1'b0;
        lvl_r <= 1'b0;
      end else begin
        upd_r <= drive;
        if (drive) out_r <= data_nxt[i];
        stb_r <= pin_evt[i] & listen;
        if (pin_evt[i] && listen) lvl_r <= lvl_bit;
      end
    end

    assign pin_out[i] = out_r;
    assign pin_upd[i] = upd_r;
    assign smp_stb[i] = stb_r;
    assign smp_lvl[i] = lvl_r;
  end

endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
  import gpio_alias_pkg::*;
#(
  parameter int unsigned NPIN  = 16,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned MUX_W = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned OFF_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_size,
  input  logic [OFF_W-1:0]      bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic [1:0]            bus_err,
  output logic [NPIN-1:0]       pin_out,
  output logic [NPIN-1:0]       pin_upd,
  input  logic [NPIN-1:0]       pin_evt,
  input  logic [NPIN*LVL_W-1:0] pin_lvl,
  output logic [NPIN-1:0]       smp_stb,
  output logic [NPIN-1:0]       smp_lvl
);

  reg_sel_e         sel;
  logic             wr_ok;
  logic             rd_ok;
  logic [1:0]       err_now;
  logic [NPIN-1:0]  fer_r;
  logic [NPIN-1:0]  data_r;
  logic [NPIN-1:0]  dir_r;
  logic [NPIN-1:0]  inen_r;
  logic [MUX_W-1:0] mux_r;
  logic [NPIN-1:0]  data_nxt;
  logic             refresh;

  gpio_bus_decode #(.OFF_W(OFF_W)) u_decode (
    .rd    (bus_rd),
    .wr    (bus_wr),
    .size  (bus_size),
    .addr  (bus_addr),
    .sel   (sel),
    .wr_ok (wr_ok),
    .rd_ok (rd_ok),
    .err   (err_now)
  );

  gpio_reg_bank #(.NPIN(NPIN), .MUX_W(MUX_W), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .sel      (sel),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .fer_q    (fer_r),
    .data_q   (data_r),
    .dir_q    (dir_r),
    .inen_q   (inen_r),
    .mux_q    (mux_r),
    .data_nxt (data_nxt),
    .refresh  (refresh)
  );

  gpio_pin_io #(.NPIN(NPIN), .LVL_W(LVL_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .refresh  (refresh),
    .data_nxt (data_nxt),
    .inen     (inen_r),
    .dir      (dir_r),
    .fer      (fer_r),
    .pin_evt  (pin_evt),
    .pin_lvl  (pin_lvl),
    .pin_out  (pin_out),
    .pin_upd  (pin_upd),
    .smp_stb  (smp_stb),
    .smp_lvl  (smp_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_err <= ERR_NONE;
    else        bus_err <= err_now;
  end

endmodule

// File: rtl/gpio_alias_port_chk.sv
module gpio_alias_port_chk #(
  parameter int unsigned NPIN  = 16,
  parameter int unsigned MUX_W = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned OFF_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [1:0]       bus_size,
  input logic [OFF_W-1:0] bus_addr,
  input logic [DW-1:0]    bus_rdata,
  input logic [1:0]       bus_err,
  input logic [NPIN-1:0]  pin_upd,
  input logic [NPIN-1:0]  smp_stb,
  input logic [NPIN-1:0]  fer_r,
  input logic [NPIN-1:0]  data_r,
  input logic [NPIN-1:0]  dir_r,
  input logic [NPIN-1:0]  inen_r,
  input logic [MUX_W-1:0] mux_r
);

  AST_ERR_FREEZES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err != 2'd0) |-> (data_r == $past(data_r) && dir_r == $past(dir_r) &&
      fer_r == $past(fer_r) && inen_r == $past(inen_r) && mux_r == $past(mux_r))); // R2

  AST_UNMAPPED_NEEDS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err == 2'd2) |-> $past(bus_size == 2'd1)); // R3

  AST_UPD_SKIPS_LISTENERS: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_upd & inen_r) == '0); // R7

  AST_UPD_ONLY_AFTER_REFRESH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_upd) |-> $past(bus_wr && bus_size == 2'd1 &&
      (bus_addr == OFF_W'(4) || bus_addr == OFF_W'(8) ||
       bus_addr == OFF_W'(12) || bus_addr == OFF_W'(16)))); // R8

  AST_SAMPLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|smp_stb) |-> ((smp_stb & $past(dir_r | ~inen_r | ~fer_r)) == '0)); // R9

  AST_RDATA_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata != '0) |-> $past(bus_rd && !bus_wr)); // R10

endmodule

bind gpio_alias_port gpio_alias_port_chk #(
  .NPIN(NPIN), .MUX_W(MUX_W), .DW(DW), .OFF_W(OFF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_size  (bus_size),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .pin_upd   (pin_upd),
  .smp_stb   (smp_stb),
  .fer_r     (fer_r),
  .data_r    (data_r),
  .dir_r     (dir_r),
  .inen_r    (inen_r),
  .mux_r     (mux_r)
);

// File: tb/gpio_alias_port_bench.sv
module gpio_alias_port_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [5:0]  bus_addr = 6'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [1:0]  bus_err;
  logic [15:0] pin_out;
  logic [15:0] pin_upd;
  logic [15:0] pin_evt = 16'd0;
  logic [31:0] pin_lvl = 32'd0;
  logic [15:0] smp_stb;
  logic [15:0] smp_lvl;

  gpio_alias_port u_gpio_alias_port (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .pin_out(pin_out),
    .pin_upd(pin_upd), .pin_evt(pin_evt), .pin_lvl(pin_lvl),
    .smp_stb(smp_stb), .smp_lvl(smp_lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model of the register state, built from the requirements.
  logic [15:0] m_fer = 0, m_data = 0, m_dir = 0, m_inen = 0, m_smp = 0, m_pin = 0;
  logic [31:0] m_mux = 0;

  // Scoreboard queues of expected bus responses.
  logic [31:0] q_rd[$];
  logic [1:0]  q_err[$];
  string       q_tag[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares the registered response the cycle after each access.
  always @(negedge clk) begin
    if (q_rd.size() != 0) begin
      logic [31:0] er;
      logic [1:0]  ee;
      string t;
      er = q_rd.pop_front();
      ee = q_err.pop_front();
      t  = q_tag.pop_front();
      check({t, " rdata"}, bus_rdata, er);
      check({t, " err"}, 32'(bus_err), 32'(ee));
    end
  end

  // Driver: one access, expected response pushed, pin outputs checked.
  task automatic access(input bit is_wr, input logic [1:0] sz, input logic [5:0] a,
                        input logic [31:0] wd, input string tag);
    logic [1:0]  e;
    logic [31:0] r;
    logic [15:0] exp_upd;
    bit          mapped, route, refresh;
    route   = (a == 6'h1C);
    mapped  = (a[1:0] == 2'b00) && (a[5] == 1'b0);
    r       = 32'd0;
    refresh = 1'b0;
    if (route ? (sz != 2'd2) : (sz != 2'd1)) e = 2'd1;
    else if (!mapped)                        e = 2'd2;
    else                                     e = 2'd0;
    if (e == 2'd0) begin
      if (is_wr) begin
        case (a[4:2])
          3'd0: m_fer = wd[15:0];
          3'd1: begin m_data = wd[15:0];           refresh = 1'b1; end
          3'd2: begin m_data = m_data | wd[15:0];  refresh = 1'b1; end
          3'd3: begin m_data = m_data & ~wd[15:0]; refresh = 1'b1; end
          3'd4: begin m_dir  = m_dir | wd[15:0];   refresh = 1'b1; end
          3'd5: m_dir = m_dir & ~wd[15:0];
          3'd6: m_inen = wd[15:0];
          default: m_mux = wd;
        endcase
      end else begin
        case (a[4:2])
          3'd0:             r = {16'd0, m_fer};
          3'd1, 3'd2, 3'd3: r = {16'd0, m_data};
          3'd4, 3'd5:       r = {16'd0, m_dir};
          3'd6:             r = {16'd0, m_inen};
          default:          r = m_mux;
        endcase
      end
    end
    if (refresh) begin
      m_pin   = (m_pin & m_inen) | (m_data & ~m_inen);
      exp_upd = ~m_inen;
    end else begin
      exp_upd = 16'd0;
    end
    @(negedge clk);
    bus_rd    = !is_wr;
    bus_wr    = is_wr;
    bus_size  = sz;
    bus_addr  = a;
    bus_wdata = wd;
    @(posedge clk);
    q_rd.push_back(r);
    q_err.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    check(refresh ? "R7 pin_out" : "R8 pin_out", 32'(pin_out), 32'(m_pin));
    check(refresh ? "R7 pin_upd" : "R8 pin_upd", 32'(pin_upd), 32'(exp_upd));
  endtask

  task automatic wr16(input logic [5:0] a, input logic [15:0] v, input string tag);
    access(1'b1, 2'd1, a, {16'd0, v}, tag);
  endtask

  task automatic rd16(input logic [5:0] a, input string tag);
    access(1'b0, 2'd1, a, 32'd0, tag);
  endtask

  // One pin event; the forwarded sample is checked the next cycle.
  task automatic pin_event(input int idx, input logic [1:0] lvl, input string tag);
    bit          gate;
    logic [15:0] exp_stb;
    gate    = m_fer[idx] && m_inen[idx] && !m_dir[idx];
    exp_stb = gate ? (16'd1 << idx) : 16'd0;
    if (gate) m_smp[idx] = |lvl;
    @(negedge clk);
    pin_evt = 16'd1 << idx;
    pin_lvl = 32'(lvl) << (2 * idx);
    @(posedge clk);
    @(negedge clk);
    pin_evt = 16'd0;
    check({tag, " smp_stb"}, 32'(smp_stb), 32'(exp_stb));
    check({tag, " smp_lvl"}, 32'(smp_lvl), 32'(m_smp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports and in every register
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 err", 32'(bus_err), 32'd0);
    check("R1 pin_out", 32'(pin_out), 32'd0);
    check("R1 pin_upd", 32'(pin_upd), 32'd0);
    check("R1 smp", {smp_stb, smp_lvl}, 32'd0);
    for (int k = 0; k < 7; k++) rd16(6'(4 * k), "R1 reg");
    access(1'b0, 2'd2, 6'h1C, 32'd0, "R1 route");

    // R6, R4, R7: masks, data and its aliases
    wr16(6'h00, 16'hFFFF, "R6 fer write");
    wr16(6'h18, 16'h00F0, "R6 listen write");
    rd16(6'h00, "R6 fer read");
    rd16(6'h18, "R6 listen read");
    wr16(6'h04, 16'h1234, "R4 data write");
    rd16(6'h04, "R6 data read");
    wr16(6'h08, 16'h00F1, "R4 data set");
    rd16(6'h08, "R6 set alias read");
    wr16(6'h0C, 16'h1004, "R4 data clear");
    rd16(6'h0C, "R6 clear alias read");

    // R5: direction through aliases only
    wr16(6'h10, 16'h0300, "R5 dir set");
    rd16(6'h10, "R5 dir set read");
    wr16(6'h14, 16'h0100, "R5 dir clear");
    rd16(6'h14, "R5 dir clear read");
    wr16(6'h04, 16'h0000, "R5 data write leaves dir");
    rd16(6'h10, "R5 dir unchanged");

    // R8: writes that do not refresh
    wr16(6'h04, 16'hA5A5, "R7 refresh before");
    wr16(6'h00, 16'h00FF, "R8 fer write");
    wr16(6'h18, 16'h10F0, "R8 listen write");
    wr16(6'h14, 16'h0000, "R8 dir clear");
    access(1'b1, 2'd2, 6'h1C, 32'hDEADBEEF, "R11 route write");
    access(1'b0, 2'd2, 6'h1C, 32'd0, "R11 route read");
    @(negedge clk);
    check("R10 idle rdata", bus_rdata, 32'd0);
    check("R10 idle err", 32'(bus_err), 32'd0);

    // R7: listening pins hold their outputs
    wr16(6'h08, 16'h0F0F, "R7 set with listeners");

    // R2: wrong sizes change nothing
    access(1'b1, 2'd0, 6'h04, 32'h0000FFFF, "R2 byte data write");
    access(1'b1, 2'd1, 6'h1C, 32'h00001111, "R2 half route write");
    access(1'b1, 2'd2, 6'h10, 32'h0000FFFF, "R2 word dir set");
    access(1'b0, 2'd2, 6'h00, 32'd0, "R2 word fer read");
    rd16(6'h04, "R2 data kept");
    rd16(6'h10, "R2 dir kept");
    access(1'b0, 2'd2, 6'h1C, 32'd0, "R2 route kept");

    // R3: unmapped offsets and size priority
    rd16(6'h24, "R3 high offset half");
    rd16(6'h02, "R3 misaligned half");
    access(1'b0, 2'd2, 6'h24, 32'd0, "R3 high offset word");
    access(1'b1, 2'd0, 6'h26, 32'h0000FFFF, "R3 misaligned byte");
    wr16(6'h20, 16'hFFFF, "R3 unmapped write");
    rd16(6'h04, "R3 data kept");
    rd16(6'h18, "R3 listen kept");

    // R9: input forwarding and its gating
    pin_event(4, 2'd2, "R9 level two normalised");
    pin_event(4, 2'd0, "R9 level zero");
    pin_event(6, 2'd3, "R9 other pin");
    wr16(6'h10, 16'h0020, "R9 dir set pin5");
    pin_event(5, 2'd1, "R9 blocked by dir");
    pin_event(1, 2'd1, "R9 blocked by listen");
    pin_event(12, 2'd1, "R9 blocked by fer");
    wr16(6'h14, 16'h0020, "R9 dir clear pin5");
    pin_event(5, 2'd1, "R9 unblocked");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule